// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port synchronous static memory with a 32-bit word split into four byte lanes. Every control and address input is sampled on the rising clock edge. The data bus is modelled as three ports: a data input, a registered data output, and a drive enable that stands for the tri-state buffer. An access begins when one of two address strobes is asserted. The strobe for a bus master always opens a read. The strobe for a cache controller can write in the same cycle.

Once an access has started, later cycles with no strobe continue it. They either hold the current word or step a two-bit wrap-around counter. The counter follows a linear or an interleaved order, chosen by a static mode input. Read data comes out of an output register one clock after the address is taken. The drive enable is pipelined, so the bus stays driven for one more cycle after a deselect and stays quiet during the first read cycle after one. Any write cycle forces the bus quiet. The asynchronous output enable gates the drive enable directly. A sleep input freezes the block after a two-clock settling time. Sleep keeps the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: A read whose address is taken at edge k has the word at that address on `dout`, with `dq_oe` high, after edge k+1, provided `oe_n` is low and edge k+1 takes no write.
- R2: An access opened with `adsp_n` low is a read, whatever the write controls and `adv_n` are at that edge. A write applied at the following edge, with no strobe, goes to the burst address of that edge.
- R3: With `adsc_n` low, `adsp_n` high and the chip selected, active write controls write `din` at that same edge. When both strobes are low, only the `adsp_n` access is performed, which is a read.
- R4: Lane i is bits 8i+7..8i. With `gw_n` low all four lanes are written. Otherwise lane i is written only when `bwe_n` is low and `bw_n[i]` is low. With `bwe_n` high, `bw_n` has no effect. Lanes that are not written keep their contents.
- R5: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe while unselected deselects the chip and writes nothing. `adsp_n` is ignored while `ce1_n` is high.
- R6: The two low address bits at burst step n from base b are (b+n) mod 4 when `lin_mode`=1 and b XOR n when `lin_mode`=0. Step n starts at 0 when a strobe loads the address. It advances by one at each edge with no strobe and `adv_n` low, wrapping after 3, and holds when `adv_n` is high.
- R7: After any edge that performs a write, `dq_oe` is low until the next edge, whatever `oe_n` is.
- R8: After a deselect at edge k, data from a read taken at edge k-1 is still driven after edge k, and `dq_oe` is low after edge k+1. A read taken right after a deselect is not driven during its first cycle.
- R9: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge. Returning it low restores the drive within the same cycle.
- R10: `zz` takes effect two edges after it changes. While asleep, strobes, writes and reads are ignored, the contents are kept and `dq_oe` is low. After wake-up the chip is idle and undriven until a new strobe arrives.
- R11: During and right after reset, `dq_oe` is low and no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | AW | Word address, taken when a strobe is honoured |
| ce1_n | input | 1 | Chip enable, active low; also qualifies `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Master address strobe, active low, always opens a read |
| adsc_n | input | 1 | Controller address strobe, active low, may write at once |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write of all lanes, active low |
| bwe_n | input | 1 | Enables the lane selects, active low |
| bw_n | input | BYTES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | DW | Write data from the bus |
| dout | output | DW | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
On every cycle the assertions check the quiet-bus rules: no drive after a controller-strobe write or a burst write, no drive after two back-to-back deselects, and no drive once sleep has been requested for two edges. Only the bench scenarios can show the data itself. These scenarios cover the read latency, the linear and interleaved step orders with holds and wrap-around, the lane masks, the writes that must not land (first cycle of a master-strobe access, unselected chip, sleep), and the pass-through of the output enable within a cycle.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH = 1024,
  parameter int BYTES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [BYTES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             zz,
  input  logic             lin_mode,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic [1:0]    zz_q;
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [AW-1:0] acc_addr_q;
  logic          rd_q, wr_q, drv_q;
  logic [DW-1:0] dout_q;

  wire asleep   = zz_q[1];
  wire chip_sel = !ce1_n && ce2 && !ce3_n;
  wire p_strobe = !adsp_n && !ce1_n;
  wire c_strobe = !adsc_n && !p_strobe;

  logic [BYTES-1:0] lane_we;
  assign lane_we = !gw_n ? {BYTES{1'b1}} : (!bwe_n ? ~bw_n : {BYTES{1'b0}});
  wire wr_req = |lane_we;

  wire load = !asleep && (p_strobe || c_strobe);
  wire cont = !asleep && !load && active_q;

  wire [1:0] cnt_nx = cnt_q + {1'b0, !adv_n};
  wire [1:0] low_nx = lin_mode ? (base_q[1:0] + cnt_nx) : (base_q[1:0] ^ cnt_nx);
  wire [AW-1:0] cyc_addr = load ? addr : {base_q[AW-1:2], low_nx};

  wire do_rd = (load && chip_sel && (p_strobe || !wr_req)) || (cont && !wr_req);
  wire do_wr = (load && chip_sel && c_strobe && wr_req) || (cont && wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zz_q       <= '0;
      active_q   <= 1'b0;
      base_q     <= '0;
      cnt_q      <= '0;
      acc_addr_q <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      drv_q      <= 1'b0;
    end else begin
      zz_q <= {zz_q[0], zz};
      if (asleep) begin
        active_q <= 1'b0;
      end else if (load) begin
        active_q <= chip_sel;
        base_q   <= addr;
        cnt_q    <= '0;
      end else if (cont) begin
        cnt_q <= cnt_nx;
      end
      acc_addr_q <= cyc_addr;
      rd_q       <= do_rd;
      wr_q       <= do_wr;
      drv_q      <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      for (int b = 0; b < BYTES; b++)
        if (lane_we[b]) mem[cyc_addr][8*b +: 8] <= din[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rd_q) dout_q <= mem[acc_addr_q];
  end

  assign dout  = dout_q;
  assign dq_oe = drv_q && !wr_q && !oe_n && !asleep;

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [BYTES-1:0] bw_n,
  input logic             zz,
  input logic             dq_oe,
  input logic             active_q
);

  wire sel_in = !ce1_n && ce2 && !ce3_n;
  wire wr_in  = !gw_n || (!bwe_n && !(&bw_n));
  wire strobe = (!adsp_n && !ce1_n) || !adsc_n;
  wire dsel   = strobe && !sel_in;

  assert_c_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && adsp_n && sel_in && wr_in && !$past(zz, 2)) |=> !dq_oe);

  assert_burst_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !strobe && wr_in && !$past(zz, 2)) |=> !dq_oe);

  assert_dcd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dsel && $past(dsel)) |=> !dq_oe);

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(zz) && $past(zz, 2)) |-> !dq_oe);

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.BYTES(BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
  .zz(zz), .dq_oe(dq_oe), .active_q(active_q)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz, lin_mode;
  logic [3:0] bw_n;
  logic [31:0] din, dout;
  logic dq_oe;

  int total = 0, failed = 0;
  logic [31:0] ref_m [64];

  always #4 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .lin_mode(lin_mode), .din(din),
    .dout(dout), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] pat(int a);
    return 32'h5A5A_0000 ^ (32'h1000_0000 + 32'(a) * 32'h0001_0203);
  endfunction

  function automatic int step_addr(int mode, int base, int n);
    return mode ? ((base + n) % 4) : (base ^ n);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual=%h expected=%h (dq_oe=%b)", req, act, exp, dq_oe);
    end
  endtask

  task automatic set_idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic dsel();
    set_idle(); adsc_n = 0; ce2 = 0; tick();
  endtask

  task automatic wr_c(int a, logic [31:0] d, logic [3:0] bwn, logic gwn, logic bwen);
    logic [3:0] m;
    set_idle(); adsc_n = 0; addr = AW'(a); din = d; gw_n = gwn; bwe_n = bwen; bw_n = bwn;
    tick();
    m = !gwn ? 4'hF : (!bwen ? ~bwn : 4'h0);
    for (int b = 0; b < 4; b++) if (m[b]) ref_m[a][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rd_c(int a);
    set_idle(); adsc_n = 0; addr = AW'(a); tick();
  endtask

  task automatic sweep(int lo, int hi, string req);
    for (int a = lo; a <= hi; a++) begin
      rd_c(a);
      if (a > lo) chk(dq_oe && dout == ref_m[a-1], req, dout, ref_m[a-1]);
    end
    dsel();
    chk(dq_oe && dout == ref_m[hi], req, dout, ref_m[hi]);
    dsel();
  endtask

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL R1: watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int n, prev;
    set_idle(); zz = 0; lin_mode = 1; addr = '0; rst_n = 0;
    repeat (3) tick();
    chk(!dq_oe, "R11", {31'b0, dq_oe}, 0);
    rst_n = 1; tick();
    chk(!dq_oe, "R11", {31'b0, dq_oe}, 0);

    for (int a = 0; a < 64; a++) wr_c(a, pat(a), 4'h0, 1'b0, 1'b1);
    sweep(0, 63, "R1");

    for (int m = 0; m < 16; m++) wr_c(m, ~pat(m), ~4'(m), 1'b1, 1'b0);
    wr_c(20, 32'hDEAD_BEEF, 4'h0, 1'b1, 1'b1);
    sweep(0, 20, "R4");

    rd_c(5); wr_c(6, 32'h0BAD_F00D, 4'h0, 1'b0, 1'b1);
    chk(!dq_oe, "R7", {31'b0, dq_oe}, 0);
    dsel(); chk(!dq_oe, "R7", {31'b0, dq_oe}, 0);

    set_idle(); adsp_n = 0; adsc_n = 0; addr = 7; gw_n = 0; din = 32'h7777_7777; tick();
    dsel(); chk(dq_oe && dout == ref_m[7], "R3", dout, ref_m[7]);
    dsel();

    set_idle(); adsc_n = 0; ce2 = 0; addr = 8; gw_n = 0; din = 32'h1111_1111; tick();
    set_idle(); adsc_n = 0; ce3_n = 1; addr = 9; gw_n = 0; din = 32'h2222_2222; tick();
    set_idle(); ce1_n = 1; adsp_n = 0; adsc_n = 0; addr = 10; gw_n = 0; din = 32'h3333_3333; tick();
    dsel(); dsel();
    set_idle(); ce1_n = 1; adsp_n = 0; addr = 11; tick();
    chk(!dq_oe, "R5", {31'b0, dq_oe}, 0);
    dsel(); chk(!dq_oe, "R5", {31'b0, dq_oe}, 0);
    sweep(8, 11, "R5");

    lin_mode = 1;
    set_idle(); adsp_n = 0; addr = 12; gw_n = 0; adv_n = 0; din = 32'hAAAA_0001; tick();
    set_idle(); adv_n = 0; gw_n = 0; din = 32'hBBBB_0002; tick();
    ref_m[13] = 32'hBBBB_0002;
    chk(!dq_oe, "R2", {31'b0, dq_oe}, 0);
    dsel(); dsel();
    sweep(12, 13, "R2");

    for (int mode = 0; mode < 2; mode++)
      for (int base = 0; base < 4; base++) begin
        lin_mode = mode[0];
        set_idle(); adsp_n = 0; addr = AW'(40 + base); tick();
        n = 0; prev = 40 + base;
        for (int j = 0; j < 5; j++) begin
          set_idle(); adv_n = (j == 3);
          if (!adv_n) n = (n + 1) % 4;
          tick();
          chk(dq_oe && dout == ref_m[prev], "R6", dout, ref_m[prev]);
          prev = 40 + step_addr(mode, base, n);
        end
        dsel(); chk(dq_oe && dout == ref_m[prev], "R6", dout, ref_m[prev]);
        dsel();
      end
    lin_mode = 1;

    rd_c(3); dsel();
    chk(dq_oe && dout == ref_m[3], "R8", dout, ref_m[3]);
    dsel(); chk(!dq_oe, "R8", {31'b0, dq_oe}, 0);
    rd_c(4); chk(!dq_oe, "R8", {31'b0, dq_oe}, 0);
    dsel(); chk(dq_oe && dout == ref_m[4], "R8", dout, ref_m[4]);
    dsel();

    rd_c(2); dsel();
    #1 oe_n = 1;
    #1 chk(!dq_oe, "R9", {31'b0, dq_oe}, 0);
    oe_n = 0;
    #1 chk(dq_oe && dout == ref_m[2], "R9", dout, ref_m[2]);
    dsel();

    zz = 1; dsel(); dsel();
    set_idle(); adsc_n = 0; addr = 1; gw_n = 0; din = 32'hCAFE_CAFE; tick();
    chk(!dq_oe, "R10", {31'b0, dq_oe}, 0);
    rd_c(2); chk(!dq_oe, "R10", {31'b0, dq_oe}, 0);
    zz = 0;
    for (int k = 0; k < 3; k++) begin
      dsel(); chk(!dq_oe, "R10", {31'b0, dq_oe}, 0);
    end
    sweep(1, 2, "R10");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule